// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block sits between a set of derived clocks and the pins they leave on. Its outputs fall into three groups: a processor group, a bus group and a group of other clocks. Each output is forwarded or held low according to a per-output enable word and two active-low halt pins, one per group. A strap input can switch the halt pins off, and an active-low sleep input shuts down every output. All of these inputs are asynchronous. They are re-timed onto a free-running reference clock, which is also the source of the bus group.

When the requested state of an output changes, the change is not applied at once. The request first steps through one more rising edge of the reference clock. The gate of that output then changes only on the next falling edge of its own clock. Because the gate moves only while the clock is low, the output is never a shortened high pulse. A stopped output rests at logic low. When the sleep input is released, or after reset, the block keeps every output off for a programmable number of reference cycles while the oscillators settle. It then raises a valid flag.

An output goes back to its earlier state with no visible change if its request reverts while the reference-edge step is still pending.

Top module: `clk_stop_ctrl`

## Requirements
- R1: A stopped output, and every output while `rst_n` is low, is logic 0.
- R2: Every high pulse on an output lasts exactly the high phase of its source clock, including the first pulse after a start and the last pulse before a stop.
- R3: A request change is re-timed by two reference flops. It then waits one further reference rising edge, and the gate follows on the next falling edge of the target clock. The output therefore keeps its old behaviour for at least two reference cycles after an input change, and has settled within twelve.
- R4: Output i (bit i of `clk_en` and `clk_out`) runs only when `clk_en[i]` is 1 and its group halt allows it. Indices 0 to N_CPU-1 form the processor group, the next N_PCI indices form the bus group, and the remaining indices form the other group.
- R5: With `halt_pins_off` = 0, `cpu_halt_n` = 0 halts the processor group and `pci_halt_n` = 0 halts the bus group. With `halt_pins_off` = 1, both halt pins are ignored.
- R6: While `sleep_n` is 0, every output is held low after the handoff latency, whatever the other inputs are, and `clk_valid` is 0.
- R7: A processor halt leaves the bus and other groups running. A bus halt leaves the processor and other groups running.
- R8: After reset release, or after `sleep_n` returns to 1, every output stays off and `clk_valid` stays 0 for STAB_CYCLES reference cycles. Only then do the outputs start.
- R9: A request that returns to its former value while its output waits for the reference edge is dropped, and the output keeps running with no missing pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock; also the bus-group source |
| rst_n | input | 1 | Asynchronous active-low reset |
| tgt_clk | input | N | Source clock of each output |
| clk_en | input | N | Per-output enable, asynchronous |
| cpu_halt_n | input | 1 | Active-low processor-group halt, asynchronous |
| pci_halt_n | input | 1 | Active-low bus-group halt, asynchronous |
| halt_pins_off | input | 1 | 1 makes both halt pins ignored |
| sleep_n | input | 1 | Active-low global power-down, asynchronous |
| clk_out | output | N | Gated clock outputs |
| clk_valid | output | 1 | Oscillator settling interval complete |

## Verification
The bench measures the width of every high pulse on every output, across all starts and stops. A gate that moved on a rising edge, or was cleared asynchronously, would leave a sliver pulse and fail that width check. It checks that an output still toggles two reference cycles after its request drops, which exposes a design that skipped the re-timing or the reference step. It pulses an enable low for exactly one reference cycle and counts pulses, so a controller that cannot cancel would show a gap of several clock periods. Power-down and reset are followed by a window in which any pulse before the settling count ends is an error.

// File: rtl/clk_stop_ctrl.sv
`timescale 1ns/1ps
module clk_stop_ctrl #(
  parameter int N_CPU = 4,
  parameter int N_PCI = 6,
  parameter int N_OTH = 2,
  parameter int STAB_CYCLES = 6667,
  localparam int N = N_CPU + N_PCI + N_OTH
) (
  input  logic         ref_clk,
  input  logic         rst_n,
  input  logic [N-1:0] tgt_clk,
  input  logic [N-1:0] clk_en,
  input  logic         cpu_halt_n,
  input  logic         pci_halt_n,
  input  logic         halt_pins_off,
  input  logic         sleep_n,
  output logic [N-1:0] clk_out,
  output logic         clk_valid
);
  localparam int CW = $clog2(STAB_CYCLES + 1);
  localparam int W = N + 4;
  localparam logic [1:0] S_RUN = 2'd0, S_WREF = 2'd1, S_WFALL = 2'd2, S_STOP = 2'd3;

  logic [W-1:0] in_s1, in_s2;
  logic [N-1:0] en_s, grp_ok, req, tq, cmd, ack_s1, ack_s2, gate;
  logic [N-1:0][1:0] st;
  logic cpu_ok, pci_ok, awake_s, ready;
  logic [CW-1:0] cnt;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      in_s1 <= '0;
      in_s2 <= '0;
    end else begin
      in_s1 <= {halt_pins_off, sleep_n, pci_halt_n, cpu_halt_n, clk_en};
      in_s2 <= in_s1;
    end

  assign en_s    = in_s2[N-1:0];
  assign cpu_ok  = in_s2[N+3] | in_s2[N];
  assign pci_ok  = in_s2[N+3] | in_s2[N+1];
  assign awake_s = in_s2[N+2];

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!awake_s) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      if (cnt == CW'(STAB_CYCLES - 1)) ready <= 1'b1;
      else cnt <= cnt + 1'b1;
    end

  assign clk_valid = ready;

  for (genvar i = 0; i < N; i++) begin : g_out
    logic g;
    if (i < N_CPU) begin : g_cpu
      assign grp_ok[i] = cpu_ok;
    end else if (i < N_CPU + N_PCI) begin : g_pci
      assign grp_ok[i] = pci_ok;
    end else begin : g_oth
      assign grp_ok[i] = 1'b1;
    end
    always_ff @(negedge tgt_clk[i] or negedge rst_n)
      if (!rst_n) g <= 1'b0;
      else g <= cmd[i];
    assign gate[i]    = g;
    assign clk_out[i] = tgt_clk[i] & g;
  end

  assign req = en_s & grp_ok & {N{ready}};

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      ack_s1 <= '0;
      ack_s2 <= '0;
    end else begin
      ack_s1 <= gate;
      ack_s2 <= ack_s1;
    end

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      st  <= {N{S_STOP}};
      tq  <= '0;
      cmd <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        case (st[i])
          S_RUN:  if (!req[i]) begin st[i] <= S_WREF; tq[i] <= 1'b0; end
          S_STOP: if (req[i])  begin st[i] <= S_WREF; tq[i] <= 1'b1; end
          S_WREF:
            if (req[i] != tq[i]) st[i] <= tq[i] ? S_STOP : S_RUN;
            else begin
              st[i]  <= S_WFALL;
              cmd[i] <= tq[i];
            end
          default:
            if (ack_s2[i] == cmd[i]) st[i] <= cmd[i] ? S_RUN : S_STOP;
        endcase
      end
    end
endmodule

module clk_stop_chk #(
  parameter int N = 12
) (
  input logic            ref_clk,
  input logic            rst_n,
  input logic            awake_s,
  input logic            ready,
  input logic [N-1:0]    req,
  input logic [N-1:0]    tq,
  input logic [N-1:0]    cmd,
  input logic [N-1:0][1:0] st,
  input logic [N-1:0]    clk_out
);
  localparam logic [1:0] S_RUN = 2'd0, S_WREF = 2'd1, S_WFALL = 2'd2, S_STOP = 2'd3;

  AST_SLEEP_DROPS_VALID: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !awake_s |=> !ready); // R6
  AST_NO_REQ_UNSETTLED: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !ready |-> (req == '0)); // R8

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_STOPPED_LOW: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (st[i] == S_STOP) |-> (clk_out[i] == 1'b0)); // R1
    AST_REF_STEP: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (st[i] == S_WREF && req[i] == tq[i]) |=> (st[i] == S_WFALL && cmd[i] == tq[i])); // R3
    AST_CMD_HOLD: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (st[i] == S_WFALL && $past(st[i]) == S_WFALL) |-> $stable(cmd[i])); // R3
    AST_REVERT_DROP: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (st[i] == S_WREF && req[i] != tq[i]) |=> (st[i] == (tq[i] ? S_STOP : S_RUN))); // R9
  end
endmodule

bind clk_stop_ctrl clk_stop_chk #(.N(N)) u_chk (
  .ref_clk(ref_clk), .rst_n(rst_n), .awake_s(awake_s), .ready(ready),
  .req(req), .tq(tq), .cmd(cmd), .st(st), .clk_out(clk_out)
);

// File: tb/sim_clk_stop_ctrl.sv
`timescale 1ns/1ps
module sim_clk_stop_ctrl;
  localparam int NC = 4, NP = 6, NO = 2, N = NC + NP + NO, STAB = 40;
  localparam logic [N-1:0] ALL = '1;
  localparam logic [N-1:0] CPU_M = N'((1 << NC) - 1);
  localparam logic [N-1:0] PCI_M = N'(((1 << NP) - 1) << NC);

  logic ref_clk = 0, cpu_c = 0, oth_c = 0;
  always #2 ref_clk = ~ref_clk;
  initial begin #0.25; forever #1 cpu_c = ~cpu_c; end
  initial begin #0.75; forever #3 oth_c = ~oth_c; end

  logic rst_n = 0, cpu_halt_n = 1, pci_halt_n = 1, halt_pins_off = 0, sleep_n = 1;
  logic [N-1:0] clk_en = '1;
  logic [N-1:0] tgt, clk_out;
  logic clk_valid;
  assign tgt = {{NO{oth_c}}, {NP{ref_clk}}, {NC{cpu_c}}};

  clk_stop_ctrl #(.N_CPU(NC), .N_PCI(NP), .N_OTH(NO), .STAB_CYCLES(STAB)) u0 (
    .ref_clk(ref_clk), .rst_n(rst_n), .tgt_clk(tgt), .clk_en(clk_en),
    .cpu_halt_n(cpu_halt_n), .pci_halt_n(pci_halt_n), .halt_pins_off(halt_pins_off),
    .sleep_n(sleep_n), .clk_out(clk_out), .clk_valid(clk_valid));

  int checks = 0, fails = 0;
  bit done = 0;
  int pcnt [N];
  int d [N];
  real tr [N];

  function automatic real half_per(int i);
    return (i < NC) ? 1.0 : (i < NC + NP) ? 2.0 : 3.0;
  endfunction

  for (genvar g = 0; g < N; g++) begin : g_mon
    initial pcnt[g] = 0;
    always @(posedge clk_out[g]) begin pcnt[g]++; tr[g] = $realtime; end
    always @(negedge clk_out[g]) begin
      real w;
      w = $realtime - tr[g];
      checks++;
      if (w < half_per(g) - 0.01 || w > half_per(g) + 0.01) begin
        fails++;
        $display("FAIL R2 out %0d high width actual=%0.3f expected=%0.3f", g, w, half_per(g));
      end
    end
  end

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge ref_clk);
  endtask

  task automatic measure(int n);
    int snap [N];
    for (int i = 0; i < N; i++) snap[i] = pcnt[i];
    cyc(n);
    @(negedge ref_clk);
    for (int i = 0; i < N; i++) d[i] = pcnt[i] - snap[i];
  endtask

  task automatic expect_run(logic [N-1:0] m, string rq);
    measure(10);
    for (int i = 0; i < N; i++)
      if (m[i]) chk(d[i] > 0, rq, $sformatf("out %0d running pulses", i), d[i], 1);
      else chk(d[i] == 0 && clk_out[i] == 1'b0, rq, $sformatf("out %0d stopped low pulses", i), d[i], 0);
  endtask

  task automatic t_reset;
    cyc(3); @(negedge ref_clk);
    chk(clk_out == '0, "R1", "outputs in reset", int'(clk_out), 0);
    rst_n = 1;
    measure(20);
    for (int i = 0; i < N; i++) chk(d[i] == 0, "R8", $sformatf("out %0d before settle", i), d[i], 0);
    chk(clk_valid == 1'b0, "R8", "valid before settle", clk_valid, 0);
    cyc(40);
    chk(clk_valid == 1'b1, "R8", "valid after settle", clk_valid, 1);
    expect_run(ALL, "R8");
  endtask

  task automatic t_enable;
    @(negedge ref_clk); clk_en = ALL & ~N'(12'h821);
    cyc(16); expect_run(ALL & ~N'(12'h821), "R4");
    @(negedge ref_clk); clk_en = ALL;
    cyc(16); expect_run(ALL, "R4");
  endtask

  task automatic t_halts;
    @(negedge ref_clk); cpu_halt_n = 0;
    cyc(16); expect_run(ALL & ~CPU_M, "R7");
    @(negedge ref_clk); cpu_halt_n = 1; pci_halt_n = 0;
    cyc(16); expect_run(ALL & ~PCI_M, "R7");
    @(negedge ref_clk); pci_halt_n = 1; clk_en[1] = 0;
    cyc(16); expect_run(ALL & ~N'(2), "R4");
    @(negedge ref_clk); clk_en[1] = 1;
    cyc(16);
  endtask

  task automatic t_mode;
    @(negedge ref_clk); halt_pins_off = 1; cpu_halt_n = 0; pci_halt_n = 0;
    cyc(16); expect_run(ALL, "R5");
    @(negedge ref_clk); halt_pins_off = 0;
    cyc(16); expect_run(ALL & ~CPU_M & ~PCI_M, "R5");
    @(negedge ref_clk); cpu_halt_n = 1; pci_halt_n = 1;
    cyc(16); expect_run(ALL, "R5");
  endtask

  task automatic t_handoff;
    @(negedge ref_clk); clk_en[2] = 0;
    measure(2);
    chk(d[2] > 0, "R3", "out 2 still running right after request", d[2], 1);
    cyc(10);
    measure(10);
    chk(d[2] == 0, "R3", "out 2 stopped within settle time", d[2], 0);
    @(negedge ref_clk); clk_en[2] = 1;
    measure(2);
    chk(d[2] == 0, "R3", "out 2 still stopped right after request", d[2], 0);
    cyc(10);
    measure(10);
    chk(d[2] > 0, "R3", "out 2 restarted", d[2], 1);
  endtask

  task automatic t_revert;
    int snap;
    @(negedge ref_clk);
    snap = pcnt[1];
    clk_en[1] = 0;
    @(negedge ref_clk); clk_en[1] = 1;
    cyc(15); @(negedge ref_clk);
    chk(pcnt[1] - snap >= 31, "R9", "out 1 pulses across reverted request", pcnt[1] - snap, 32);
  endtask

  task automatic t_sleep;
    @(negedge ref_clk); sleep_n = 0;
    cyc(16); expect_run('0, "R6");
    chk(clk_valid == 1'b0, "R6", "valid while asleep", clk_valid, 0);
    @(negedge ref_clk); sleep_n = 1;
    measure(20);
    for (int i = 0; i < N; i++) chk(d[i] == 0, "R8", $sformatf("out %0d after wake", i), d[i], 0);
    cyc(40);
    expect_run(ALL, "R8");
  endtask

  initial begin
    t_reset;
    t_enable;
    t_halts;
    t_mode;
    t_handoff;
    t_revert;
    t_sleep;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge ref_clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule